// File: doc/BRIEF.md
# Quad Programmable Sample-Clock Divider

This block produces four independent sample-rate strobes from the system clock. Each strobe is meant to run at sixteen times a serial bit rate, so that an oversampling receiver can use it. Each generator has one 32-bit control word. The word holds the divide ratio minus one as a 12-bit field, an enable flag and a flag that places a fixed divide-by-16 stage in front of the counter. That stage covers rates too slow for the counter alone.

Software writes a control word and the matching generator starts to emit one-cycle clock-enable pulses. A new ratio written while a generator runs is adopted only at its next reload, so the period in progress keeps its length. The four control words sit at consecutive 32-bit word addresses. The interface is plain control, with no valid/ready handshake, because nothing flows through the block: a write lands in one cycle and reads return combinationally. The strobes are single-cycle enables, not data, so no back-pressure applies.

Top module: `brg_bank`

## Requirements
- R1: After reset every control word reads as zero and no generator pulses.
- R2: With the prescaler off and ratio field D, a running generator pulses every D+1 clocks. The first pulse comes D+1 clocks after the write that enabled it takes effect.
- R3: With the prescaler flag (bit 17) set, the period becomes 16*(D+1) clocks, and two pulses are never closer than 16 clocks.
- R4: While the enable flag (bit 16) is clear, the generator produces no pulses, whatever ratio is stored.
- R5: Clearing the enable flag resets the counter and the prescaler, so a later re-enable starts with a full period.
- R6: A ratio written while a generator runs first applies after the next pulse. The period in progress is neither cut short nor stretched.
- R7: The ratio field occupies bits 12:1. A control word reads back with bit 0, bits 15:13 and bits 31:18 as zero.
- R8: Generator g is selected by byte address bits [3:2] equal to g, and address bits 1:0 are ignored. A write to one generator leaves the others unchanged.
- R9: The full 12-bit range works: D=0 gives a pulse on every clock, and D=4095 gives a period of 4096 clocks.
- R10: Each pulse is one clock wide whenever the period exceeds one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for a control word |
| wr_addr | input | 4 | Byte address of the written word |
| wr_data | input | 32 | Control word to write |
| rd_addr | input | 4 | Byte address of the word to read |
| rd_data | output | 32 | Control word selected by rd_addr, reserved bits zero |
| tick | output | 4 | One-cycle clock-enable pulse, one bit per generator |

## Verification
The bench retimes a running generator in the middle of a period. A design that reloads at once would produce a short period, and one that ignores the new value would keep the old spacing. It disables a generator in the middle of a count and re-enables it on the next clock. A counter that is not cleared would fire early.

It also covers the limits of the range. At D=0 a design with an off-by-one would skip cycles. At D=4095 a counter narrower than 12 bits would wrap and fire far too often. In prescaled mode, a stage that is not cleared on enable would put the first pulse at the wrong time. Two generators run at the same time with different rates, and one of them is written through an address with its low bits set, to expose crossed decode.

// File: rtl/brg_pkg.sv
`timescale 1ns/1ps
package brg_pkg;
  localparam int REG_W        = 32;
  localparam int DIV_W_DEF    = 12;
  localparam int PRE_LOG2_DEF = 4;
  localparam int EN_POS       = 16;
  localparam int PRE_POS      = 17;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} brg_state_e;
endpackage

// File: rtl/brg_regs.sv
`timescale 1ns/1ps
module brg_regs #(
  parameter int NUM_GEN = 4,
  parameter int DIV_W   = 12,
  parameter int ADDR_W  = 4,
  parameter int EN_BIT  = 16,
  parameter int PRE_BIT = 17
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [31:0]                 rd_data,
  output logic [NUM_GEN-1:0]          cfg_en,
  output logic [NUM_GEN-1:0]          cfg_pre,
  output logic [NUM_GEN-1:0][DIV_W-1:0] cfg_div
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             unused_bits;

  assign wr_idx      = wr_addr[ADDR_W-1:2];
  assign rd_idx      = rd_addr[ADDR_W-1:2];
  assign unused_bits = ^{wr_addr[1:0], rd_addr[1:0], wr_data};

  // one control word per generator
  for (genvar g = 0; g < NUM_GEN; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_en[g]  <= 1'b0;
        cfg_pre[g] <= 1'b0;
        cfg_div[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        cfg_en[g]  <= wr_data[EN_BIT];
        cfg_pre[g] <= wr_data[PRE_BIT];
        cfg_div[g] <= wr_data[DIV_W:1];
      end
    end
  end

  // combinational readback, undefined bits zero
  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NUM_GEN; g++) begin
      if (rd_idx == IDX_W'(g)) begin
        rd_data[DIV_W:1]  = cfg_div[g];
        rd_data[EN_BIT]   = cfg_en[g];
        rd_data[PRE_BIT]  = cfg_pre[g];
      end
    end
  end
endmodule

// File: rtl/brg_prescale.sv
`timescale 1ns/1ps
module brg_prescale #(
  parameter int PRE_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel,
  output logic step
);
  logic [PRE_LOG2-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end

  // bypass: step every running clock; prescaled: once per wrap
  assign step = sel ? (run && (pcnt == '1)) : run;

  AST_PCNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt == '0)); // R5
endmodule

// File: rtl/brg_counter.sv
`timescale 1ns/1ps
module brg_counter
  import brg_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  brg_state_e       state;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] eff;

  // first running cycle takes the live ratio, later periods the latched one
  assign eff = (state == ST_RUN) ? lim : reload;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      lim   <= '0;
      tick  <= 1'b0;
    end else if (!run) begin
      state <= ST_IDLE;
      cnt   <= '0;
      tick  <= 1'b0;
    end else begin
      state <= ST_RUN;
      tick  <= 1'b0;
      if (state == ST_IDLE) lim <= reload;
      if (step) begin
        if (cnt == eff) begin
          tick <= 1'b1;
          cnt  <= '0;
          lim  <= reload;
        end else begin
          cnt  <= cnt + 1'b1;
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (cnt <= lim)); // R6
  AST_TICK_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(step)); // R2
endmodule

// File: rtl/brg_bank.sv
`timescale 1ns/1ps
module brg_bank
  import brg_pkg::*;
#(
  parameter int NUM_GEN  = 4,
  parameter int DIV_W    = DIV_W_DEF,
  parameter int PRE_LOG2 = PRE_LOG2_DEF,
  parameter int ADDR_W   = $clog2(NUM_GEN) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [31:0]        rd_data,
  output logic [NUM_GEN-1:0] tick
);
  localparam logic [31:0] RD_MASK = (32'((1 << DIV_W) - 1) << 1)
                                  | (32'd1 << EN_POS) | (32'd1 << PRE_POS);

  logic [NUM_GEN-1:0]            cfg_en;
  logic [NUM_GEN-1:0]            cfg_pre;
  logic [NUM_GEN-1:0][DIV_W-1:0] cfg_div;
  logic [NUM_GEN-1:0]            step;

  brg_regs #(
    .NUM_GEN (NUM_GEN),
    .DIV_W   (DIV_W),
    .ADDR_W  (ADDR_W),
    .EN_BIT  (EN_POS),
    .PRE_BIT (PRE_POS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cfg_en  (cfg_en),
    .cfg_pre (cfg_pre),
    .cfg_div (cfg_div)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    brg_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (cfg_en[g]),
      .sel   (cfg_pre[g]),
      .step  (step[g])
    );

    brg_counter #(.DIV_W(DIV_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (cfg_en[g]),
      .step   (step[g]),
      .reload (cfg_div[g]),
      .tick   (tick[g])
    );

    AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[g] && cfg_pre[g] && $past(cfg_pre[g])) |=> !tick[g]); // R3
  end

  AST_RDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr[ADDR_W-1:2] == rd_addr[ADDR_W-1:2]))
    |=> (!$stable(rd_addr[ADDR_W-1:2]) || (rd_data == ($past(wr_data) & RD_MASK)))); // R7
endmodule

// File: tb/test_brg_bank.sv
`timescale 1ns/1ps
module test_brg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  int exp_q [4][$];
  string cur_req [4];

  localparam logic [31:0] EN  = 32'h0001_0000;
  localparam logic [31:0] PRE = 32'h0002_0000;

  brg_bank i_brg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // caller sits at a negedge; returns the edge that lands the write
  task automatic wr(input logic [3:0] a, input logic [31:0] d, output int e);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    e = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic push(input int g, input int first, input int p, input int last);
    for (int t = first; t <= last; t += p) exp_q[g].push_back(t);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      for (int g = 0; g < 4; g++) begin
        while (exp_q[g].size() > 0 && exp_q[g][0] < cyc) begin
          checks++; errors++;
          $display("FAIL %s: gen %0d missed pulse, actual none expected edge %0d",
                   cur_req[g], g, exp_q[g][0]);
          void'(exp_q[g].pop_front());
        end
        if (tick[g]) begin
          checks++;
          if (exp_q[g].size() == 0 || exp_q[g][0] != cyc) begin
            errors++;
            $display("FAIL %s: gen %0d pulse at edge %0d, expected edge %0d",
                     cur_req[g], g, cyc, (exp_q[g].size() > 0) ? exp_q[g][0] : -1);
          end else begin
            void'(exp_q[g].pop_front());
          end
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e, e2, x;
    logic [31:0] d;
    for (int g = 0; g < 4; g++) cur_req[g] = "R2";
    repeat (3) @(negedge clk);
    chk(tick == 4'b0, "R1", tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    for (int g = 0; g < 4; g++) begin
      rd(4'(g * 4), d);
      chk(d == 32'h0, "R1", d, 0);
    end
    chk(tick == 4'b0, "R1", tick, 0);

    // R7 / R8 readback and decode
    @(negedge clk);
    wr(4'hC, 32'hFFFF_FFFF, e);
    rd(4'hC, d); chk(d == 32'h0003_1FFE, "R7", d, 32'h0003_1FFE);
    for (int g = 0; g < 3; g++) begin
      rd(4'(g * 4 + 1), d); chk(d == 32'h0, "R8", d, 0);
    end
    @(negedge clk);
    wr(4'hC, 32'h0, e);
    rd(4'hE, d); chk(d == 32'h0, "R7", d, 0);

    // R4: ratio stored but enable clear
    wr(4'h0, 32'h0000_0002, e);
    repeat (30) begin
      @(negedge clk); chk(tick == 4'b0, "R4", tick, 0);
    end
    rd(4'h0, d); chk(d == 32'h2, "R7", d, 2);

    // R2: divide by 5
    cur_req[0] = "R2";
    wr(4'h0, EN | (32'd4 << 1), e);
    x = e + 60; push(0, e + 5, 5, x);
    wait_until(x - 1); wr(4'h0, 32'h0, e);

    // R9: divide by 1 and divide by 4096
    cur_req[1] = "R9";
    wr(4'h4, EN, e);
    x = e + 20; push(1, e + 1, 1, x);
    wait_until(x - 1); wr(4'h4, 32'h0, e);
    @(negedge clk);
    wr(4'h4, EN | (32'd4095 << 1), e);
    x = e + 4096 * 2 + 10; push(1, e + 4096, 4096, x);
    wait_until(x - 1); wr(4'h4, 32'h0, e);

    // R3: prescaled, D=5 and D=0
    cur_req[2] = "R3";
    @(negedge clk);
    wr(4'h8, EN | PRE | (32'd5 << 1), e);
    x = e + 400; push(2, e + 96, 96, x);
    wait_until(x - 1); wr(4'h8, 32'h0, e);
    @(negedge clk);
    wr(4'h8, EN | PRE, e);
    x = e + 100; push(2, e + 16, 16, x);
    wait_until(x - 1); wr(4'h8, 32'h0, e);

    // R8: two generators at once, one via address with low bits set
    cur_req[0] = "R8"; cur_req[3] = "R8";
    @(negedge clk);
    wr(4'h0, EN | (32'd2 << 1), e);
    wr(4'hF, EN | PRE | (32'd6 << 1), e2);
    x = e2 + 500;
    push(0, e + 3, 3, x);
    push(3, e2 + 112, 112, x + 1);
    wait_until(x - 1); wr(4'h0, 32'h0, e);
    wr(4'hC, 32'h0, e);

    // R6: retime in the middle of a period
    cur_req[2] = "R6";
    @(negedge clk);
    wr(4'h8, EN | (32'd9 << 1), e);
    exp_q[2].push_back(e + 10);
    exp_q[2].push_back(e + 20);
    exp_q[2].push_back(e + 30);
    x = e + 80; push(2, e + 34, 4, x);
    wait_until(e + 23); wr(4'h8, EN | (32'd3 << 1), e2);
    wait_until(x - 1); wr(4'h8, 32'h0, e);

    // R5: disable mid-count and re-enable on the next clock
    cur_req[1] = "R5";
    @(negedge clk);
    wr(4'h4, EN | (32'd7 << 1), e);
    x = e + 21; push(1, e + 8, 8, x);
    wait_until(x - 1); wr(4'h4, 32'h0, e);
    wr(4'h4, EN | (32'd7 << 1), e2);
    x = e2 + 30; push(1, e2 + 8, 8, x);
    wait_until(x - 1); wr(4'h4, 32'h0, e);

    // R4 / R10: all quiet after disable
    @(negedge clk);
    repeat (40) begin
      @(negedge clk); chk(tick == 4'b0, "R4", tick, 0);
    end
    for (int g = 0; g < 4; g++)
      chk(exp_q[g].size() == 0, "R10", exp_q[g].size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule